// File: doc/BRIEF.md
# Unaligned Byte-Row Extractor

This block rebuilds a row of pixel bytes that starts at an arbitrary byte address from a group of 32-bit words fetched from the word-aligned address just below it. The caller truncates the start address to a 4-byte boundary, fetches three consecutive little-endian words from there, and presents them together with the low two bits of the original address as a byte offset. The block funnels the words so that the first byte of the result is the byte at the true start address.

Two modes exist. In row mode the block returns the eight bytes of the row and clears the second output. In interpolation mode it also returns a second eight-byte vector that starts one byte later, covering source bytes one to eight. A horizontal half-pixel filter then has both of its operands in the same cycle. Results are registered once. The output valid flag follows the input valid flag one cycle later, and the data outputs keep their value while no new group arrives.

Top module: `xrow_extract`

## Requirements
- R1: While reset is asserted and after its release until the first valid group, out_valid is 0 and out_base and out_shift are all zero.
- R2: The source bytes are numbered from 0 to 11, little-endian: source byte j is in_words[8j+7:8j], so byte 0 is the least significant byte of word 0. One cycle after a valid group, byte k of out_base (bits 8k+7:8k, k = 0..7) equals source byte in_offset+k.
- R3: In row mode with offset 0, word 2 (in_words[95:64]) has no effect on either output.
- R4: At offset 3, the three low bytes of word 0 (in_words[23:0]) have no effect on either output. Only the top byte of word 0 becomes byte 0 of the row.
- R5: In interpolation mode (in_mode = 1), byte k of out_shift equals source byte in_offset+k+1 for every offset, so bytes 1..8 are delivered.
- R6: In row mode (in_mode = 0), out_shift is all zero one cycle after the group.
- R7: out_valid is 1 in exactly the cycle after each cycle in which in_valid is 1.
- R8: When in_valid is 0, out_base and out_shift keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Word group and control are valid this cycle |
| in_mode | input | 1 | 0 = row mode, 1 = interpolation mode |
| in_offset | input | 2 | Byte offset of the true start address inside word 0 |
| in_words | input | 96 | Three consecutive words, word 0 in bits 31:0 |
| out_valid | output | 1 | Registered results are new this cycle |
| out_base | output | 64 | Row bytes 0..7, byte 0 in bits 7:0 |
| out_shift | output | 64 | Row bytes 1..8 in interpolation mode, zero in row mode |

## Verification
A selector that picks the wrong byte lane shows at out_base or out_shift in the cycle right after the offending group. Because every lane has its own selector, the fault appears for every offset that reaches that lane. A capture enable that is stuck or inverted shows within one cycle: either the data changes while in_valid is low, or out_valid fails to match the delayed input flag. A wrong mode register would leave stale data in out_shift after a row-mode group, and that shows as a nonzero shifted vector in the very next cycle.

// File: rtl/xrow_pkg.sv
package xrow_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int ROW_BYTES  = 8;
  localparam int OFF_W      = $clog2(WORD_BYTES);
  localparam int IN_WORDS   = ROW_BYTES / WORD_BYTES + 1;
  localparam int IN_BYTES   = IN_WORDS * WORD_BYTES;

  typedef enum logic {
    MODE_ROW    = 1'b0,
    MODE_INTERP = 1'b1
  } xrow_mode_e;
endpackage

// File: rtl/xrow_window.sv
module xrow_window #(
  parameter int BYTE_W  = 8,
  parameter int N_IN    = 12,
  parameter int N_OUT   = 8,
  parameter int OFF_W   = 2,
  parameter int SKEW    = 0
) (
  input  logic [N_IN*BYTE_W-1:0]  src,
  input  logic [OFF_W-1:0]        offset,
  output logic [N_OUT*BYTE_W-1:0] dst
);
  localparam int IDX_W = $clog2(N_IN) + 1;

  for (genvar k = 0; k < N_OUT; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    always_comb begin
      idx = IDX_W'(offset) + IDX_W'(k + SKEW);
      dst[k*BYTE_W +: BYTE_W] = '0;
      if (int'(idx) < N_IN)
        dst[k*BYTE_W +: BYTE_W] = src[int'(idx)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/xrow_stage.sv
module xrow_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] base_d,
  input  logic [DATA_W-1:0] shift_d,
  output logic              valid_q,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] shift_q
);
  logic [DATA_W-1:0] base_n, shift_n;

  always_comb begin
    base_n  = base_q;
    shift_n = shift_q;
    if (cap_en) begin
      base_n  = base_d;
      shift_n = shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      shift_q <= '0;
    end else begin
      valid_q <= cap_en;
      base_q  <= base_n;
      shift_q <= shift_n;
    end
  end

  // R7 valid tracks capture one cycle later
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> valid_q);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !valid_q);
  // R8 data held without capture
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> ($stable(base_q) && $stable(shift_q)));
endmodule

// File: rtl/xrow_extract.sv
module xrow_extract
  import xrow_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_mode,
  input  logic [OFF_W-1:0]             in_offset,
  input  logic [IN_BYTES*BYTE_W-1:0]   in_words,
  output logic                         out_valid,
  output logic [ROW_BYTES*BYTE_W-1:0]  out_base,
  output logic [ROW_BYTES*BYTE_W-1:0]  out_shift
);
  localparam int ROW_W = ROW_BYTES * BYTE_W;

  logic [ROW_W-1:0] base_win, shift_win, shift_sel;
  xrow_mode_e       mode;

  assign mode = xrow_mode_e'(in_mode);

  xrow_window #(.BYTE_W(BYTE_W), .N_IN(IN_BYTES), .N_OUT(ROW_BYTES),
                .OFF_W(OFF_W), .SKEW(0)) u_base_win (
    .src(in_words), .offset(in_offset), .dst(base_win));

  xrow_window #(.BYTE_W(BYTE_W), .N_IN(IN_BYTES), .N_OUT(ROW_BYTES),
                .OFF_W(OFF_W), .SKEW(1)) u_shift_win (
    .src(in_words), .offset(in_offset), .dst(shift_win));

  always_comb begin
    shift_sel = '0;
    if (mode == MODE_INTERP) shift_sel = shift_win;
  end

  xrow_stage #(.DATA_W(ROW_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .cap_en(in_valid),
    .base_d(base_win), .shift_d(shift_sel),
    .valid_q(out_valid), .base_q(out_base), .shift_q(out_shift));

  // R6 row mode clears the shifted vector
  a_r6_row_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MODE_ROW) |=> (out_shift == '0));
  // R5 shifted vector overlaps base by one byte in interpolation mode
  a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MODE_INTERP) |=>
      (out_shift[ROW_W-BYTE_W-1:0] == out_base[ROW_W-1:BYTE_W]));
  // R1 reset state
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && out_base == '0 && out_shift == '0));
endmodule

// File: tb/xrow_extract_tb.sv
module xrow_extract_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_mode;
  logic [1:0]  in_offset;
  logic [95:0] in_words;
  logic        out_valid;
  logic [63:0] out_base, out_shift;

  int vectors = 0;
  int errors  = 0;
  string req  = "R1";

  logic        exp_valid;
  logic [63:0] exp_base, exp_shift;

  always #2.5 clk = ~clk;

  xrow_extract u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_offset(in_offset), .in_words(in_words), .out_valid(out_valid),
    .out_base(out_base), .out_shift(out_shift));

  // behavioural reference: byte array view of the word group
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_valid = 1'b0;
      exp_base  = '0;
      exp_shift = '0;
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        byte unsigned bytes [12];
        for (int j = 0; j < 12; j++) bytes[j] = in_words[8*j +: 8];
        for (int k = 0; k < 8; k++) begin
          exp_base[8*k +: 8]  = bytes[int'(in_offset) + k];
          exp_shift[8*k +: 8] = in_mode ? bytes[int'(in_offset) + k + 1] : 8'h00;
        end
      end
    end
  end

  task automatic compare();
    vectors++;
    if (out_valid !== exp_valid || out_base !== exp_base || out_shift !== exp_shift) begin
      errors++;
      $display("FAIL %s: got v=%b base=%h shift=%h expected v=%b base=%h shift=%h",
               req, out_valid, out_base, out_shift, exp_valid, exp_base, exp_shift);
    end
  endtask

  task automatic step(input logic v, input logic m, input logic [1:0] o,
                      input logic [95:0] w);
    in_valid = v; in_mode = m; in_offset = o; in_words = w;
    @(negedge clk);
    compare();
  endtask

  task automatic same_check(input string tag, input logic [63:0] b0,
                            input logic [63:0] s0);
    vectors++;
    if (out_base !== b0 || out_shift !== s0) begin
      errors++;
      $display("FAIL %s: got base=%h shift=%h expected base=%h shift=%h",
               tag, out_base, out_shift, b0, s0);
    end
  endtask

  initial begin
    logic [63:0] sb, ss;
    logic [95:0] w;
    rst_n = 1'b0; in_valid = 0; in_mode = 0; in_offset = 0; in_words = '0;
    repeat (3) @(negedge clk);
    req = "R1"; compare();
    rst_n = 1'b1;
    @(negedge clk); compare();
    w = 96'h0b0a0908_07060504_03020100;
    req = "R2";
    for (int o = 0; o < 4; o++) step(1, 0, 2'(o), w);
    req = "R5";
    for (int o = 0; o < 4; o++) step(1, 1, 2'(o), w);
    req = "R6"; step(1, 0, 2'd2, w);
    req = "R8";
    for (int i = 0; i < 3; i++) step(0, 1, 2'(i), {3{$urandom()}});
    // R3 word 2 ignored in row mode at offset 0
    req = "R3";
    step(1, 0, 2'd0, 96'h11111111_89abcdef_01234567);
    sb = out_base; ss = out_shift;
    step(1, 0, 2'd0, 96'hffffffff_89abcdef_01234567);
    same_check("R3", sb, ss);
    // R4 low bytes of word 0 ignored at offset 3
    req = "R4";
    for (int m = 0; m < 2; m++) begin
      step(1, 1'(m), 2'd3, 96'h55667788_11223344_a0000000);
      sb = out_base; ss = out_shift;
      step(1, 1'(m), 2'd3, 96'h55667788_11223344_a0fedcba);
      same_check("R4", sb, ss);
    end
    // R7 with random traffic, all modes and offsets
    req = "R7";
    for (int i = 0; i < 400; i++)
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           2'($urandom_range(0, 3)), {$urandom(), $urandom(), $urandom()});
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule